// File: doc/BRIEF.md
# Autocorrelation-Sign Gain Tracking Loop

This block is a slow digital servo for a sampled regulator controller. It keeps a loop-gain coefficient and trims it over time. On every accepted cycle it takes only the sign bit of the quantized error sample and compares it with the sign bit of the previous accepted sample. Two equal signs in a row suggest a sluggish, over-damped loop. Alternating signs suggest ringing, which is an under-damped loop. A signed tally collects these votes over a fixed window of samples.

When a window closes, a large positive tally raises the coefficient by one step and a large negative tally lowers it by one step. A tally of small magnitude leaves it unchanged. The coefficient never leaves a fixed range. The controller reads the coefficient directly. The controller can use the one-cycle update strobe to tell when a window has just closed.

Top module: `sign_corr_gain_servo`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `gain` equals GAIN_INIT and `upd_stb` is 0. Reset also clears the remembered previous sign to 0 (non-negative) and empties the window.
- R2: Only bit ERR_W-1 of `err_smp` is used, where 1 means negative error. The lower bits have no effect on any output.
- R3: Each accepted sample adds +1 to the window tally when its sign bit equals the sign bit of the previous accepted sample, and -1 when it differs.
- R4: A window holds exactly WINDOW accepted samples (default 40). The decision is taken on the clock edge that accepts the last of them, and the next window starts from a tally of zero.
- R5: If the window's final tally is at least +THRESH (default 8), `gain` rises by STEP.
- R6: If the window's final tally is at most -THRESH, `gain` falls by STEP.
- R7: If the final tally lies strictly between -THRESH and +THRESH, `gain` is unchanged.
- R8: `gain` saturates. It never rises above GAIN_MAX and never falls below GAIN_MIN.
- R9: `upd_stb` is high for exactly one cycle after each window closes, whether or not `gain` changed. It becomes visible in the same cycle as the new `gain`.
- R10: A sample is accepted only when `en` and `smp_vld` are both high. Any other sample neither advances the window nor updates the remembered sign.
- R11: `gain` changes only in a cycle in which `upd_stb` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Regulator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Tracking enable |
| smp_vld | input | 1 | Error sample valid this cycle |
| err_smp | input | ERR_W | Signed quantized error sample |
| gain | output | GAIN_W | Loop-gain coefficient |
| upd_stb | output | 1 | One-cycle pulse at each window close |

## Verification
Two things can happen on the same edge: the last sample of a window tips the tally across the threshold, and the window closes and clears the tally. The bench provokes this by placing the deciding sign flips so that the final sample decides the outcome. It uses 16 flips, which gives exactly +8 and a step up, and 17 flips, which gives +6 and a hold. It judges the result by the gain value seen together with the strobe. A window close can also meet a saturated gain. Repeated windows in one direction drive the gain into each bound, where the strobe must still pulse while the value stays put.

// File: rtl/scg_pkg.sv
package scg_pkg;

  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } gain_dir_e;

  // +1 when consecutive signs agree, -1 when they alternate
  function automatic int corr_vote(input logic mismatch);
    return mismatch ? -1 : 1;
  endfunction

  // decision from a closed window tally
  function automatic gain_dir_e judge(input int total, input int thresh);
    if (total >= thresh)  return DIR_UP;
    if (total <= -thresh) return DIR_DOWN;
    return DIR_HOLD;
  endfunction

  // saturating single step
  function automatic int sat_move(input int g, input gain_dir_e d,
                                  input int step, input int lo, input int hi);
    int r;
    r = g;
    if (d == DIR_UP)        r = (g + step > hi) ? hi : g + step;
    else if (d == DIR_DOWN) r = (g - step < lo) ? lo : g - step;
    return r;
  endfunction

endpackage

// File: rtl/scg_corr.sv
module scg_corr (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic err_sign,
  output logic mismatch
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    prev_q <= 1'b0;
    else if (take) prev_q <= err_sign;
  end

  assign mismatch = err_sign ^ prev_q;

  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> prev_q == $past(prev_q)); // R10
endmodule

// File: rtl/scg_window.sv
module scg_window #(
  parameter int WINDOW = 40,
  parameter int CNT_W  = 6,
  parameter int ACC_W  = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take,
  input  logic                    mismatch,
  output logic                    win_last,
  output logic signed [ACC_W-1:0] win_total
);
  import scg_pkg::*;

  logic [CNT_W-1:0]        cnt_q;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] vote;

  assign vote      = ACC_W'(corr_vote(mismatch));
  assign win_total = acc_q + vote;
  assign win_last  = take && (cnt_q == CNT_W'(WINDOW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (win_last) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (take) begin
      cnt_q <= cnt_q + 1'b1;
      acc_q <= win_total;
    end
  end

  AST_WCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < WINDOW); // R4
  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(acc_q) <= int'(cnt_q)) && (int'(acc_q) >= -int'(cnt_q))); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> (cnt_q == $past(cnt_q)) && (acc_q == $past(acc_q))); // R10
endmodule

// File: rtl/scg_gain.sv
module scg_gain #(
  parameter int GAIN_W    = 10,
  parameter int GAIN_MIN  = 16,
  parameter int GAIN_MAX  = 1000,
  parameter int GAIN_INIT = 512,
  parameter int STEP      = 1,
  parameter int THRESH    = 8,
  parameter int ACC_W     = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    win_last,
  input  logic signed [ACC_W-1:0] win_total,
  output logic [GAIN_W-1:0]       gain,
  output logic                    upd_stb
);
  import scg_pkg::*;

  gain_dir_e         dir;
  logic [GAIN_W-1:0] gain_nxt;
  logic [GAIN_W-1:0] gain_q;
  logic              stb_q;

  assign dir      = judge(int'(win_total), THRESH);
  assign gain_nxt = GAIN_W'(sat_move(int'(gain_q), dir, STEP, GAIN_MIN, GAIN_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= GAIN_W'(GAIN_INIT);
      stb_q  <= 1'b0;
    end else begin
      stb_q <= win_last;
      if (win_last) gain_q <= gain_nxt;
    end
  end

  assign gain    = gain_q;
  assign upd_stb = stb_q;

  AST_GAIN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(gain_q) >= GAIN_MIN) && (int'(gain_q) <= GAIN_MAX)); // R8
  AST_GAIN_ONLY_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_q != $past(gain_q)) |-> stb_q); // R11
  AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q); // R9
  AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> (int'(gain_q) == int'($past(gain_q))) ||
              (int'(gain_q) == int'($past(gain_q)) + STEP) ||
              (int'(gain_q) == int'($past(gain_q)) - STEP)); // R5
endmodule

// File: rtl/sign_corr_gain_servo.sv
module sign_corr_gain_servo #(
  parameter int ERR_W     = 8,
  parameter int GAIN_W    = 10,
  parameter int WINDOW    = 40,
  parameter int THRESH    = 8,
  parameter int STEP      = 1,
  parameter int GAIN_MIN  = 16,
  parameter int GAIN_MAX  = 1000,
  parameter int GAIN_INIT = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              smp_vld,
  input  logic [ERR_W-1:0]  err_smp,
  output logic [GAIN_W-1:0] gain,
  output logic              upd_stb
);
  localparam int CNT_W = (WINDOW > 2) ? $clog2(WINDOW) : 1;
  localparam int ACC_W = $clog2(WINDOW + 1) + 1;

  logic                    take;
  logic                    err_sign;
  logic                    mismatch;
  logic                    win_last;
  logic signed [ACC_W-1:0] win_total;

  assign take     = en & smp_vld;
  assign err_sign = err_smp[ERR_W-1];

  generate
    if (ERR_W > 1) begin : g_low
      logic unused_low;
      assign unused_low = ^err_smp[ERR_W-2:0];
    end
  endgenerate

  scg_corr u_corr (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .err_sign (err_sign),
    .mismatch (mismatch)
  );

  scg_window #(.WINDOW(WINDOW), .CNT_W(CNT_W), .ACC_W(ACC_W)) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .mismatch  (mismatch),
    .win_last  (win_last),
    .win_total (win_total)
  );

  scg_gain #(
    .GAIN_W(GAIN_W), .GAIN_MIN(GAIN_MIN), .GAIN_MAX(GAIN_MAX),
    .GAIN_INIT(GAIN_INIT), .STEP(STEP), .THRESH(THRESH), .ACC_W(ACC_W)
  ) u_gain (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_last  (win_last),
    .win_total (win_total),
    .gain      (gain),
    .upd_stb   (upd_stb)
  );

  AST_STB_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |-> $past(en && smp_vld)); // R4
endmodule

// File: tb/sign_corr_gain_servo_bench.sv
module sign_corr_gain_servo_bench;
  localparam int ERR_W = 8, GAIN_W = 10, WIN = 40, TH = 8, STP = 1;
  localparam int GMIN = 100, GMAX = 106, GINIT = 103;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, smp_vld = 1'b0;
  logic [ERR_W-1:0]  err_smp = '0;
  logic [GAIN_W-1:0] gain;
  logic              upd_stb;

  int n_cmp = 0, n_bad = 0;
  int exp_gain = GINIT;
  logic exp_prev = 1'b0;
  int lowseed = 0;

  always #4 clk = ~clk;

  sign_corr_gain_servo #(
    .ERR_W(ERR_W), .GAIN_W(GAIN_W), .WINDOW(WIN), .THRESH(TH), .STEP(STP),
    .GAIN_MIN(GMIN), .GAIN_MAX(GMAX), .GAIN_INIT(GINIT)
  ) u_sign_corr_gain_servo (
    .clk(clk), .rst_n(rst_n), .en(en), .smp_vld(smp_vld),
    .err_smp(err_smp), .gain(gain), .upd_stb(upd_stb)
  );

  // flips per window and expected direction: tally = WIN - 2*flips
  localparam int TBL_N = 9;
  localparam int TBL_FLIPS [TBL_N] = '{0, 16, 17, 20, 23, 24, 40, 0, 5};
  localparam int TBL_DIR   [TBL_N] = '{1,  1,  0,  0,  0, -1, -1, 1, 1};

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one cycle at negedge, output sampled at following negedge
  task automatic drive(input logic e, input logic v, input logic s);
    en      = e;
    smp_vld = v;
    lowseed = lowseed + 37;
    err_smp = {s, 7'(lowseed)};
    @(negedge clk);
  endtask

  function automatic int clamp_step(input int g, input int d);
    int r;
    r = g + d * STP;
    if (r > GMAX) r = GMAX;
    if (r < GMIN) r = GMIN;
    return r;
  endfunction

  // one full window with `flips` sign changes at its start
  task automatic run_window(input int flips, input int dir, input string req);
    for (int i = 0; i < WIN; i++) begin
      logic s;
      s = (i < flips) ? ~exp_prev : exp_prev;
      drive(1'b1, 1'b1, s);
      exp_prev = s;
      if (i < WIN - 1) begin
        if (upd_stb !== 1'b0) chk({req, " R4 early strobe"}, int'(upd_stb), 0);
      end
    end
    exp_gain = clamp_step(exp_gain, dir);
    chk({req, " R9 strobe at close"}, int'(upd_stb), 1);
    chk({req, " gain after close"}, int'(gain), exp_gain);
    drive(1'b0, 1'b0, 1'b0);
    chk({req, " R9 strobe one cycle"}, int'(upd_stb), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 gain in reset", int'(gain), GINIT);
    chk("R1 strobe in reset", int'(upd_stb), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 gain after reset", int'(gain), GINIT);

    // table walk: R2 R3 R5 R6 R7 (16 flips = +8 boundary, 17 = +6, 23 = -6, 24 = -8)
    for (int k = 0; k < TBL_N; k++)
      run_window(TBL_FLIPS[k], TBL_DIR[k], "R3/R5/R6/R7 table");

    // R8 upper saturation with strobe still pulsing (R9)
    for (int k = 0; k < 3; k++) run_window(0, 1, "R8 upper");
    chk("R8 held at max", int'(gain), GMAX);
    // R8 lower saturation
    for (int k = 0; k < 9; k++) run_window(WIN, -1, "R8 lower");
    chk("R8 held at min", int'(gain), GMIN);

    // R10: ignored samples of opposite sign interleaved; must not count or touch history
    for (int i = 0; i < WIN; i++) begin
      drive(1'b0, 1'b1, ~exp_prev);
      drive(1'b1, 1'b0, ~exp_prev);
      if (upd_stb !== 1'b0) chk("R10 no strobe from ignored", int'(upd_stb), 0);
      drive(1'b1, 1'b1, exp_prev);
      if (i < WIN - 1 && upd_stb !== 1'b0) chk("R10 early strobe", int'(upd_stb), 0);
    end
    exp_gain = clamp_step(exp_gain, 1);
    chk("R10 strobe on 40th accepted", int'(upd_stb), 1);
    chk("R10 history untouched, gain up", int'(gain), exp_gain);
    drive(1'b0, 1'b0, 1'b0);

    // R2: lower bits alone vary wildly, sign fixed -> all matches -> up
    run_window(0, 1, "R2 low bits ignored");

    // R1: partial window then reset clears count and history
    for (int i = 0; i < 10; i++) drive(1'b1, 1'b1, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 gain on reset", int'(gain), GINIT);
    chk("R1 strobe on reset", int'(upd_stb), 0);
    rst_n = 1'b1;
    exp_gain = GINIT;
    exp_prev = 1'b0;
    run_window(0, 1, "R1 fresh window");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule